// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

A watchdog timer peripheral that sits on a simple word-addressed register bus. Software configures it through a 16-bit control word that is guarded against stray writes: a new configuration is accepted only directly after a two-word unlock pattern. Once enabled, the timer counts prescaled clock ticks. Software must restart the count with a second two-word key pattern before the count reaches the terminal value. That terminal value is a power of two, chosen by a one-hot exponent field.

On expiry the block sets a sticky interrupt flag. If reset generation is enabled, it also issues a one-cycle system reset request. In that case the count stops at zero until it is restarted, and a cause register records that the watchdog made the request. The same cause register also latches other reset causes, which arrive as pulses on input pins. A separate echo-mode bit can be set; while it is set, every write to the control word is discarded. Two parameters shorten the timeouts so that they can be reached in simulation: `PRESCALE` sets the number of clocks per tick, and `SIM_SHIFT` is subtracted from every exponent.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every register reads zero (word addresses: 0 control, 1 count low half, 2 count high half, 3 cause, 4 echo), and `irq_o` and `sys_rst_req_o` are low.
- R2: A write to the control word (address 0) changes the configuration only when it directly follows a full-word write of 0x3333 and then a full-word write of 0xCCCC to address 0. A lone write is ignored.
- R3: The unlock sequence is broken by any other value written to address 0, and by a write to any other address. After a break, the next configuration write is ignored.
- R4: Full-word writes of 0xAAAA and then 0x5555 to address 0 restart the count from zero. They leave the control word unchanged.
- R5: The control word has these fields: bit 15 enables counting, bit 14 enables the reset request, bit 12 is the interrupt flag, and bits 7:0 are the exponent select. While bit 15 is clear, the count stays at zero. Byte strobe bit 0 writes bits 7:0 and strobe bit 1 writes bits 15:8.
- R6: With select bit k set, expiry occurs after 2^(E-SIM_SHIFT) ticks of PRESCALE clocks each. E is 14 for k=0, 24 for k=1, and 23+k for k from 2 to 7.
- R7: If more than one select bit is set, the highest set bit decides the timeout. If the select byte is zero, the bit-7 timeout applies.
- R8: Expiry sets the interrupt flag (`irq_o`, control bit 12). The flag stays set until an unlocked configuration write has bit 12 at 1. An unlocked write with bit 12 at 0 leaves it set.
- R9: With bit 14 set, expiry gives a single-cycle `sys_rst_req_o` pulse, and the count then holds at zero until the restart keys are written. With bit 14 clear, expiry gives no pulse and counting resumes from zero.
- R10: Cause register (address 3): bit 3 is set by a watchdog reset request, and bits 0, 1 and 2 are set by the matching bits of `other_cause_i`. Writing 1 to a bit clears it.
- R11: While bit 0 of the echo register (address 4) is set, writes to address 0 are ignored, both key writes and configuration writes.
- R12: The 32-bit count can be read with its low half at address 1 and its high half at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_be_i | input | 2 | Byte strobes |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| other_cause_i | input | 3 | Pulses that record non-watchdog reset causes |
| irq_o | output | 1 | Sticky expiry flag |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong key-sequence state shows up at the very next write. A configuration word is then either accepted when it should be ignored or ignored when it should be accepted, and a control read on the following cycle reveals it. A wrong terminal-count decode shifts the cycle in which `irq_o` first rises, so the bench counts cycles from the enabling write and compares that count exactly. A count that fails to halt or to resume appears within a few cycles, either as a nonzero count read or as a missing or extra reset request pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 32;

  localparam logic [15:0] KEY_OPEN_A = 16'h3333;
  localparam logic [15:0] KEY_OPEN_B = 16'hCCCC;
  localparam logic [15:0] KEY_KICK_A = 16'hAAAA;
  localparam logic [15:0] KEY_KICK_B = 16'h5555;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_CNTLO = 3'd1;
  localparam logic [2:0] REG_CNTHI = 3'd2;
  localparam logic [2:0] REG_CAUSE = 3'd3;
  localparam logic [2:0] REG_ECHO  = 3'd4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_OPEN1 = 2'd1,
    SEQ_OPEN  = 2'd2,
    SEQ_KICK1 = 2'd3
  } seq_e;

  // Highest set bit of the select byte; bit 7 when empty.
  function automatic logic [2:0] sel_index(input logic [7:0] sel);
    logic [2:0] idx;
    idx = 3'd7;
    for (int i = 0; i < 8; i++) begin
      if (sel[i]) idx = 3'(i);
    end
    return idx;
  endfunction

  function automatic int unsigned sel_exponent(input logic [2:0] idx);
    if (idx == 3'd0) return 14;
    if (idx == 3'd1) return 24;
    return 23 + int'(idx);
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic [15:0]       rdata_o,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [3:0]        cause_i,
  output logic              cause_wr_o,
  output logic              cfg_en_o,
  output logic              cfg_wrst_o,
  output logic [7:0]        cfg_sel_o,
  output logic              flag_o,
  output logic              echo_o,
  output logic              kick_o
);
  seq_e       seq_q, seq_d;
  logic       en_q, en_d, wrst_q, wrst_d, flag_q, flag_d, echo_q, echo_d;
  logic [7:0] sel_q, sel_d;
  logic       hit_ctrl, hit_other, ctrl_acc, full, kick;

  assign hit_ctrl  = we_i && (addr_i == ADDR_W'(REG_CTRL));
  assign hit_other = we_i && (addr_i != ADDR_W'(REG_CTRL));
  assign ctrl_acc  = hit_ctrl && !echo_q;
  assign full      = (be_i == 2'b11);

  always_comb begin
    seq_d  = seq_q;
    en_d   = en_q;
    wrst_d = wrst_q;
    sel_d  = sel_q;
    flag_d = flag_q;
    echo_d = echo_q;
    kick   = 1'b0;
    if (hit_other) begin
      seq_d = SEQ_IDLE;
    end else if (ctrl_acc) begin
      if (seq_q == SEQ_OPEN) begin
        if (be_i[0]) sel_d = wdata_i[7:0];
        if (be_i[1]) begin
          en_d   = wdata_i[15];
          wrst_d = wdata_i[14];
          if (wdata_i[12]) flag_d = 1'b0;
        end
        seq_d = SEQ_IDLE;
      end else if (full && wdata_i == KEY_OPEN_A) begin
        seq_d = SEQ_OPEN1;
      end else if (full && seq_q == SEQ_OPEN1 && wdata_i == KEY_OPEN_B) begin
        seq_d = SEQ_OPEN;
      end else if (full && wdata_i == KEY_KICK_A) begin
        seq_d = SEQ_KICK1;
      end else if (full && seq_q == SEQ_KICK1 && wdata_i == KEY_KICK_B) begin
        kick  = 1'b1;
        seq_d = SEQ_IDLE;
      end else begin
        seq_d = SEQ_IDLE;
      end
    end
    if (expire_i) flag_d = 1'b1;
    if (we_i && addr_i == ADDR_W'(REG_ECHO) && be_i[0]) echo_d = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_IDLE;
      en_q   <= 1'b0;
      wrst_q <= 1'b0;
      sel_q  <= 8'h00;
      flag_q <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      en_q   <= en_d;
      wrst_q <= wrst_d;
      sel_q  <= sel_d;
      flag_q <= flag_d;
      echo_q <= echo_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(REG_CTRL):  rdata_o = {en_q, wrst_q, 1'b0, flag_q, 4'b0000, sel_q};
      ADDR_W'(REG_CNTLO): rdata_o = cnt_i[15:0];
      ADDR_W'(REG_CNTHI): rdata_o = cnt_i[31:16];
      ADDR_W'(REG_CAUSE): rdata_o = {12'h000, cause_i};
      ADDR_W'(REG_ECHO):  rdata_o = {15'h0000, echo_q};
      default:            rdata_o = 16'h0000;
    endcase
  end

  assign cause_wr_o = we_i && (addr_i == ADDR_W'(REG_CAUSE)) && be_i[0];
  assign cfg_en_o   = en_q;
  assign cfg_wrst_o = wrst_q;
  assign cfg_sel_o  = sel_q;
  assign flag_o     = flag_q;
  assign echo_o     = echo_q;
  assign kick_o     = kick;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int PRESCALE  = 16,
  parameter int SIM_SHIFT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wrst_i,
  input  logic [7:0]       sel_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             req_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, term_m1;
  logic             stop_q, stop_d, req_q, req_d, expire;
  logic [5:0]       shamt;

  always_comb begin
    shamt   = 6'(sel_exponent(sel_index(sel_i)) - SIM_SHIFT);
    term_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    stop_d = stop_q;
    expire = 1'b0;
    if (!en_i || kick_i) begin
      pre_d  = '0;
      cnt_d  = '0;
      stop_d = 1'b0;
    end else if (!stop_q) begin
      if (pre_q == PLAST) begin
        pre_d = '0;
        if (cnt_q == term_m1) begin
          expire = 1'b1;
          cnt_d  = '0;
          stop_d = wrst_i;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
    req_d = expire && wrst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
      req_q  <= req_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire;
  assign req_o    = req_q;
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (clr_we_i) cause_d = cause_d & ~clr_mask_i;
    cause_d = cause_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PRESCALE  = 16,
  parameter int SIM_SHIFT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [15:0]       bus_wdata_i,
  input  logic [1:0]        bus_be_i,
  output logic [15:0]       bus_rdata_o,
  input  logic [2:0]        other_cause_i,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  logic             rst_n;
  logic             cfg_en, cfg_wrst, irq_flag, echo_on, kick, expire, cause_wr;
  logic [7:0]       cfg_sel;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cause;

  wdog_rst_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  wdog_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk_i(clk_i), .rst_ni(rst_n),
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i), .be_i(bus_be_i),
    .rdata_o(bus_rdata_o), .expire_i(expire), .cnt_i(cnt), .cause_i(cause),
    .cause_wr_o(cause_wr), .cfg_en_o(cfg_en), .cfg_wrst_o(cfg_wrst),
    .cfg_sel_o(cfg_sel), .flag_o(irq_flag), .echo_o(echo_on), .kick_o(kick)
  );

  wdog_counter #(.PRESCALE(PRESCALE), .SIM_SHIFT(SIM_SHIFT)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(cfg_en), .wrst_i(cfg_wrst),
    .sel_i(cfg_sel), .kick_i(kick), .cnt_o(cnt), .expire_o(expire),
    .req_o(sys_rst_req_o)
  );

  wdog_cause #(.N(4)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_n),
    .set_i({expire && cfg_wrst, other_cause_i}),
    .clr_we_i(cause_wr), .clr_mask_i(bus_wdata_i[3:0]), .cause_o(cause)
  );

  assign irq_o = irq_flag;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic              req_o,
  input logic              echo_on,
  input logic              expire,
  input logic              cfg_en,
  input logic              cfg_wrst,
  input logic [7:0]        cfg_sel,
  input logic [3:0]        cause,
  input logic [31:0]       cnt
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == '0);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_o |=> !req_o);
  a_r9_halt_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_o |-> (cnt == 32'd0));
  a_r10_cause_logged: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_o |-> cause[3]);
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !ctrl_wr) |=> irq_o);
  a_r11_echo_blocks: assert property (@(posedge clk_i) disable iff (!rst_n)
    (echo_on && ctrl_wr && !expire) |=> $stable({cfg_en, cfg_wrst, cfg_sel, irq_o}));
  a_r5_off_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_en |=> (cnt == 32'd0));
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
  .irq_o(irq_o), .req_o(sys_rst_req_o), .echo_on(echo_on), .expire(expire),
  .cfg_en(cfg_en), .cfg_wrst(cfg_wrst), .cfg_sel(cfg_sel), .cause(cause), .cnt(cnt)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic [15:0] rdata;
  logic [2:0]  ocause = '0;
  logic        irq, req;
  int          total = 0, bad = 0, pulses = 0;

  always #5 clk = ~clk;

  keyed_wdog #(.ADDR_W(4), .PRESCALE(2), .SIM_SHIFT(14)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_be_i(be), .bus_rdata_o(rdata),
    .other_cause_i(ocause), .irq_o(irq), .sys_rst_req_o(req)
  );

  always @(negedge clk) if (rst_n && req) pulses++;

  // fields: addr[37:34] data[33:18] be[17:16] expected control read[15:0]
  localparam logic [37:0] VEC [0:20] = '{
    {4'h0, 16'h8081, 2'b11, 16'h0000},  // R2 lone write ignored
    {4'h0, 16'h3333, 2'b11, 16'h0000},
    {4'h0, 16'hCCCC, 2'b11, 16'h0000},
    {4'h0, 16'h0004, 2'b11, 16'h0004},  // R2 accepted
    {4'h0, 16'h0010, 2'b11, 16'h0004},  // R2 relocked
    {4'h0, 16'h3333, 2'b11, 16'h0004},
    {4'h0, 16'h1234, 2'b11, 16'h0004},  // R3 wrong value
    {4'h0, 16'hCCCC, 2'b11, 16'h0004},
    {4'h0, 16'h0020, 2'b11, 16'h0004},
    {4'h0, 16'h3333, 2'b11, 16'h0004},
    {4'h4, 16'h0000, 2'b01, 16'h0004},  // R3 other address
    {4'h0, 16'hCCCC, 2'b11, 16'h0004},
    {4'h0, 16'h0040, 2'b11, 16'h0004},
    {4'h0, 16'h3333, 2'b11, 16'h0004},
    {4'h0, 16'hCCCC, 2'b11, 16'h0004},
    {4'h0, 16'hFF02, 2'b01, 16'h0002},  // R5 low byte only
    {4'h0, 16'h3333, 2'b11, 16'h0002},
    {4'h0, 16'hCCCC, 2'b11, 16'h0002},
    {4'h0, 16'h0000, 2'b11, 16'h0000},
    {4'h0, 16'hAAAA, 2'b11, 16'h0000},  // R4 keys leave control
    {4'h0, 16'h5555, 2'b11, 16'h0000}
  };

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic cfg(input logic [15:0] v);
    wr(4'h0, 16'h3333, 2'b11);
    wr(4'h0, 16'hCCCC, 2'b11);
    wr(4'h0, v, 2'b11);
  endtask

  task automatic kick();
    wr(4'h0, 16'hAAAA, 2'b11);
    wr(4'h0, 16'h5555, 2'b11);
  endtask

  // Returns the number of cycles after the last write until irq is seen.
  task automatic wait_irq(input int limit, output int cyc);
    cyc = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (irq) begin cyc = k; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(4'(a), d); check("R1 register zero", d, 0);
    end
    check("R1 irq low", irq, 0);
    check("R1 req low", req, 0);

    // R2 / R3 / R4 / R5 table
    for (int i = 0; i < 21; i++) begin
      wr(VEC[i][37:34], VEC[i][33:18], VEC[i][17:16]);
      rd(4'h0, d);
      check($sformatf("R2/R3 vector %0d", i), d, VEC[i][15:0]);
    end

    // R6 select bit 0: 2^0 ticks x 2 clocks, no reset request
    cfg(16'h8001);
    wait_irq(100, cyc); check("R6 bit0 expiry cycle", cyc, 2);
    repeat (6) @(negedge clk);
    check("R9 no pulse without enable", pulses, 0);
    // R8 flag sticky through write with bit12=0, cleared with bit12=1
    cfg(16'h0001);
    rd(4'h0, d); check("R8 flag kept", d, 16'h1001);
    cfg(16'h1001);
    rd(4'h0, d); check("R8 flag cleared", d, 16'h0001);
    check("R8 irq low", irq, 0);

    // R6 select bit 1 and R12 mid-run count
    cfg(16'h8002);
    repeat (1000) @(negedge clk);
    rd(4'h1, d); check("R12 count low", d, 500);
    rd(4'h2, d); check("R12 count high", d, 0);
    wait_irq(5000, cyc); check("R6 bit1 expiry cycle", cyc + 1000, 2048);
    cfg(16'h1000);

    // R7 multiple bits: highest wins (bit 2)
    cfg(16'h8006);
    wait_irq(10000, cyc); check("R7 highest bit expiry", cyc, 4096);
    cfg(16'h1000);

    // R7 empty select uses bit 7 (2^16 ticks)
    cfg(16'h8000);
    wait_irq(6000, cyc); check("R7 empty select no early expiry", cyc, -1);
    rd(4'h1, d); check("R7 empty select count", d, 3000);
    cfg(16'h1000);

    // R4 restart keys
    cfg(16'h8002);
    repeat (1000) @(negedge clk);
    kick();
    rd(4'h1, d); check("R4 count restarted", d, 0);
    rd(4'h0, d); check("R4 control unchanged", d, 16'h8002);
    wait_irq(5000, cyc); check("R4 expiry after restart", cyc, 2048);
    cfg(16'h1000);

    // R9 reset request and halt; R10 cause logged
    cfg(16'hC001);
    wait_irq(100, cyc); check("R9 expiry cycle", cyc, 2);
    repeat (10) @(negedge clk);
    check("R9 single pulse", pulses, 1);
    rd(4'h1, d); check("R9 count halted", d, 0);
    rd(4'h3, d); check("R10 watchdog cause bit3", d, 16'h0008);
    kick();
    repeat (10) @(negedge clk);
    check("R9 second pulse after restart", pulses, 2);
    cfg(16'h1000);

    // R10 other causes and write-one-to-clear
    @(negedge clk); ocause = 3'b101;
    @(negedge clk); ocause = 3'b000;
    rd(4'h3, d); check("R10 other causes", d, 16'h000D);
    wr(4'h3, 16'h0005, 2'b01);
    rd(4'h3, d); check("R10 partial clear", d, 16'h0008);
    wr(4'h3, 16'h0008, 2'b01);
    rd(4'h3, d); check("R10 full clear", d, 16'h0000);

    // R11 echo mode blocks control writes
    wr(4'h4, 16'h0001, 2'b01);
    rd(4'h4, d); check("R11 echo set", d, 16'h0001);
    cfg(16'h8001);
    rd(4'h0, d); check("R11 write blocked", d, 16'h0000);
    check("R11 no irq", irq, 0);
    wr(4'h4, 16'h0000, 2'b01);
    cfg(16'h0080);
    rd(4'h0, d); check("R11 write after echo off", d, 16'h0080);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule